// File: doc/BRIEF.md
# Addressed Peripheral Register Interface with Interrupt

This block is the peripheral end of a shared byte-wide bus. The bus master marks each access with an active-low chip select, a read/write line and a single address line. When the address line is low, a write carries a command byte. The top three bits of that byte name a controller number and the low five bits carry an operation code. When the number equals this unit's own identity, the unit becomes selected and the operation code is loaded into its mode register. Any other number leaves the unit deselected. While selected, accesses with the address line high reach one of three data registers, chosen by a two-bit field in the mode register.

The unit reports back through an active-low interrupt request. The interrupt is raised once each command or parameter byte has been handled. It is cleared by any access to the mode register. It stays inactive while the enable bit of the mode register is clear. The bus output enable and the interrupt are only ever pulled low: outside an active read, and while no interrupt is pending, both rest high. A bus input is sampled on the first clock edge at which the chip select is seen low after being high.

Top module: `pirq_top`

## Requirements
- R1: After a synchronous reset, the mode register and all data registers are zero, the unit is deselected, and both `irq_n` and `bus_oe_n` are high.
- R2: A write with `a1`=0 whose bits 7:5 equal `UNIT_ID` selects the unit and loads bits 3:0 into the mode register. In the mode register, bit 0 is the enable, bit 1 is a spare control, and bits 3:2 are the register select. Bit 4 of the command byte is dropped.
- R3: A selected write with `a1`=1 stores the byte in the data register whose number is the register select (0, 1 or 2). A select of 3 discards the byte.
- R4: A selected read drives `bus_out` with `bus_oe_n` low from the clock edge that samples the access. With `a1`=1 the value driven is the chosen data register. With `a1`=0 the value driven is {UNIT_ID, 1'b0, mode}.
- R5: A command byte carrying another controller number deselects the unit. It leaves the mode register and the interrupt unchanged. Afterwards, writes with `a1`=1 are ignored and reads are not driven.
- R6: A handled byte is either a matching command write or a selected write with `a1`=1. When the enable bit is set, each handled byte pulls `irq_n` low on the second clock edge after the edge that sampled the access. Reads with `a1`=1 do not raise the interrupt.
- R7: Any access to the mode register (a selected read with `a1`=0, or a matching command write) clears a pending interrupt.
- R8: While the enable bit is clear, `irq_n` stays high, even after a handled byte.
- R9: When a clear from a mode-register access falls in the same cycle as a set from an earlier handled byte, the set wins and `irq_n` goes low.
- R10: `bus_oe_n` is low only in cycles after a sampled read with chip select low, and it returns high once the chip select is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| cs_n | input | 1 | Active-low chip select from the bus master |
| a1 | input | 1 | Address line: 0 = command/mode, 1 = data register |
| rw | input | 1 | 1 = read, 0 = write |
| bus_in | input | 8 | Bus byte from the master |
| bus_out | output | 8 | Bus byte toward the master |
| bus_oe_n | output | 1 | Active-low enable for `bus_out` |
| irq_n | output | 1 | Active-low interrupt request |
| mode_o | output | 4 | Current mode register |
| unit_sel_o | output | 1 | Unit is selected by the last command byte |
| regs_o | output | 24 | Data registers, register i at bits [8i+7:8i] |

## Verification
The interrupt set from a handled byte lands two edges after that byte is sampled. The earliest next bus access is sampled on that same edge, so a set and a mode-register clear can fall in one cycle. The bench provokes this by issuing a parameter write and following it at once with a read of the mode register. It judges the result by requiring `irq_n` to be low after the read, when the read alone would have left it high. A second pair is also covered: a data read arriving while an interrupt is pending must neither raise nor clear it.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int SEL_W  = 2;
  localparam int MODE_W = 2 + SEL_W;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             ctl;
    logic             en;
  } mode_t;
endpackage

// File: rtl/pirq_bus_front.sv
module pirq_bus_front #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          a1,
  input  logic          rw,
  output logic          ev_wr,
  output logic          ev_rd,
  output logic          ev_a1
);
  logic cs_prev_q;
  logic start;

  always_ff @(posedge clk) begin
    if (rst) cs_prev_q <= 1'b1;
    else     cs_prev_q <= cs_n;
  end

  assign start = !cs_n && cs_prev_q;
  assign ev_wr = start && !rw;
  assign ev_rd = start && rw;
  assign ev_a1 = a1;
endmodule

// File: rtl/pirq_unit_regs.sv
module pirq_unit_regs
  import pirq_pkg::*;
#(
  parameter int DW      = 8,
  parameter int ID_W    = 3,
  parameter int UNIT_ID = 0,
  parameter int NREG    = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ev_wr,
  input  logic            ev_rd,
  input  logic            ev_a1,
  input  logic [DW-1:0]   din,
  output mode_t           mode_q,
  output logic            sel_q,
  output logic [NREG*DW-1:0] regs_flat,
  output logic            handled,
  output logic            mode_access
);
  logic cmd_wr, id_match, param_wr;
  logic [DW-1:0] regs_q [NREG];

  assign cmd_wr      = ev_wr && !ev_a1;
  assign id_match    = din[DW-1 -: ID_W] == ID_W'(UNIT_ID);
  assign param_wr    = ev_wr && ev_a1 && sel_q;
  assign handled     = (cmd_wr && id_match) || param_wr;
  assign mode_access = (cmd_wr && id_match) || (ev_rd && !ev_a1 && sel_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      mode_q <= '0;
    end else if (cmd_wr) begin
      sel_q <= id_match;
      if (id_match) mode_q <= mode_t'(din[MODE_W-1:0]);
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs_q[i] <= '0;
      else if (param_wr && int'(mode_q.sel) == i) regs_q[i] <= din;
    end
    assign regs_flat[i*DW +: DW] = regs_q[i];
  end

  assert_foreign_keeps_mode_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !id_match) |=> ($stable(mode_q) && !sel_q));
  assert_unselected_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    (ev_wr && ev_a1 && !sel_q) |=> $stable(regs_flat));
  assert_match_loads_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && id_match) |=> sel_q);
endmodule

// File: rtl/pirq_irq_ctrl.sv
module pirq_irq_ctrl #(
  parameter int DELAY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic irq_n
);
  logic [DELAY-1:0] pipe_q;
  logic flag_q;
  logic set_now;

  if (DELAY == 1) begin : g_short
    always_ff @(posedge clk) begin
      if (rst) pipe_q <= '0;
      else     pipe_q <= set_i;
    end
  end else begin : g_long
    always_ff @(posedge clk) begin
      if (rst) pipe_q <= '0;
      else     pipe_q <= {pipe_q[DELAY-2:0], set_i};
    end
  end

  assign set_now = pipe_q[DELAY-1];

  always_ff @(posedge clk) begin
    if (rst)                   flag_q <= 1'b0;
    else if (set_now)          flag_q <= 1'b1;
    else if (clr_i || !en_i)   flag_q <= 1'b0;
  end

  assign irq_n = !(flag_q && en_i);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    set_now |=> flag_q);
  assert_mode_access_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_now) |=> !flag_q);
  assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (rst)
    !en_i |-> irq_n);
endmodule

// File: rtl/pirq_top.sv
module pirq_top
  import pirq_pkg::*;
#(
  parameter int DW        = 8,
  parameter int ID_W      = 3,
  parameter int UNIT_ID   = 0,
  parameter int NREG      = 3,
  parameter int IRQ_DELAY = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_n,
  input  logic                 a1,
  input  logic                 rw,
  input  logic [DW-1:0]        bus_in,
  output logic [DW-1:0]        bus_out,
  output logic                 bus_oe_n,
  output logic                 irq_n,
  output logic [MODE_W-1:0]    mode_o,
  output logic                 unit_sel_o,
  output logic [NREG*DW-1:0]   regs_o
);
  localparam int PAD_W = DW - ID_W - MODE_W;

  logic ev_wr, ev_rd, ev_a1;
  mode_t mode_q;
  logic sel_q, handled, mode_access;
  logic [NREG*DW-1:0] regs_flat;
  logic rd_ok;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] dout_q;
  logic oe_n_q;

  pirq_bus_front #(.DW(DW)) u_front (
    .clk(clk), .rst(rst), .cs_n(cs_n), .a1(a1), .rw(rw),
    .ev_wr(ev_wr), .ev_rd(ev_rd), .ev_a1(ev_a1)
  );

  pirq_unit_regs #(.DW(DW), .ID_W(ID_W), .UNIT_ID(UNIT_ID), .NREG(NREG)) u_regs (
    .clk(clk), .rst(rst), .ev_wr(ev_wr), .ev_rd(ev_rd), .ev_a1(ev_a1),
    .din(bus_in), .mode_q(mode_q), .sel_q(sel_q), .regs_flat(regs_flat),
    .handled(handled), .mode_access(mode_access)
  );

  pirq_irq_ctrl #(.DELAY(IRQ_DELAY)) u_irq (
    .clk(clk), .rst(rst), .set_i(handled), .clr_i(mode_access),
    .en_i(mode_q.en), .irq_n(irq_n)
  );

  assign rd_ok = !cs_n && rw && sel_q && (!a1 || int'(mode_q.sel) < NREG);

  always_comb begin
    rd_data = '0;
    if (!a1) begin
      rd_data = {ID_W'(UNIT_ID), {PAD_W{1'b0}}, mode_q};
    end else begin
      for (int i = 0; i < NREG; i++)
        if (int'(mode_q.sel) == i) rd_data = regs_flat[i*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_n_q <= 1'b1;
      dout_q <= '0;
    end else begin
      oe_n_q <= !rd_ok;
      dout_q <= rd_ok ? rd_data : '0;
    end
  end

  assign bus_out    = dout_q;
  assign bus_oe_n   = oe_n_q;
  assign mode_o     = mode_q;
  assign unit_sel_o = sel_q;
  assign regs_o     = regs_flat;

  assert_oe_only_on_read_R10: assert property (@(posedge clk) disable iff (rst)
    !bus_oe_n |-> $past(!cs_n && rw));
  assert_oe_needs_select_R5: assert property (@(posedge clk) disable iff (rst)
    !bus_oe_n |-> $past(sel_q));
endmodule

// File: tb/tb_pirq_top.sv
`timescale 1ns/1ps
module tb_pirq_top;
  localparam int ID = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, a1 = 1'b0, rw = 1'b1;
  logic [7:0] bus_in = '0;
  logic [7:0] bus_out;
  logic bus_oe_n, irq_n, unit_sel_o;
  logic [3:0] mode_o;
  logic [23:0] regs_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] exp_reg [3];
  logic [7:0] rd_val;
  logic rd_oe_n;

  always #4 clk = ~clk;

  pirq_top #(.UNIT_ID(ID)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .a1(a1), .rw(rw), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe_n(bus_oe_n), .irq_n(irq_n), .mode_o(mode_o),
    .unit_sel_o(unit_sel_o), .regs_o(regs_o)
  );

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < 3; i++)
      check(req, $sformatf("reg%0d", i), 32'(regs_o[i*8 +: 8]), 32'(exp_reg[i]));
  endtask

  task automatic bus_write(input logic addr, input logic [7:0] d);
    cs_n = 1'b0; a1 = addr; rw = 1'b0; bus_in = d;
    @(negedge clk);
    cs_n = 1'b1; rw = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic addr);
    cs_n = 1'b0; a1 = addr; rw = 1'b1;
    @(negedge clk);
    rd_val = bus_out; rd_oe_n = bus_oe_n;
    cs_n = 1'b1;
    @(negedge clk);
    check("R10", "oe released", 32'(bus_oe_n), 32'd1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1", "irq_n", 32'(irq_n), 32'd1);
    check("R1", "oe_n", 32'(bus_oe_n), 32'd1);
    check("R1", "mode", 32'(mode_o), 32'd0);
    check("R1", "selected", 32'(unit_sel_o), 32'd0);
    check_regs("R1");
  endtask

  task automatic t_unselected;
    bus_write(1'b1, 8'h33);
    check_regs("R5");
    bus_read(1'b1);
    check("R5", "read not driven", 32'(rd_oe_n), 32'd1);
  endtask

  task automatic t_select_disabled;
    bus_write(1'b0, 8'hA0);
    check("R2", "selected", 32'(unit_sel_o), 32'd1);
    check("R2", "mode", 32'(mode_o), 32'd0);
    bus_write(1'b1, 8'h11); exp_reg[0] = 8'h11;
    check_regs("R3");
    idle(3);
    check("R8", "irq off while disabled", 32'(irq_n), 32'd1);
  endtask

  task automatic t_enable_and_latency;
    bus_write(1'b0, 8'hB5);
    check("R2", "bit4 dropped", 32'(mode_o), 32'h5);
    check("R6", "irq not yet", 32'(irq_n), 32'd1);
    @(negedge clk);
    check("R6", "irq raised after command", 32'(irq_n), 32'd0);
    bus_read(1'b0);
    check("R4", "mode read oe", 32'(rd_oe_n), 32'd0);
    check("R4", "mode read value", 32'(rd_val), 32'hA5);
    idle(1);
    check("R7", "mode read clears", 32'(irq_n), 32'd1);
  endtask

  task automatic t_data_path;
    bus_write(1'b1, 8'h5C); exp_reg[1] = 8'h5C;
    idle(1);
    check_regs("R3");
    check("R6", "irq after param", 32'(irq_n), 32'd0);
    bus_read(1'b1);
    check("R4", "data read oe", 32'(rd_oe_n), 32'd0);
    check("R4", "data read value", 32'(rd_val), 32'h5C);
    check("R6", "data read keeps irq", 32'(irq_n), 32'd0);
    bus_read(1'b0);
    idle(1);
    check("R7", "cleared", 32'(irq_n), 32'd1);
  endtask

  task automatic t_select_three;
    bus_write(1'b0, 8'hAD);
    idle(1);
    bus_read(1'b0);
    idle(1);
    bus_write(1'b1, 8'h77);
    check_regs("R3");
    bus_read(1'b1);
    check("R3", "select 3 not driven", 32'(rd_oe_n), 32'd1);
    bus_read(1'b0);
    idle(1);
  endtask

  task automatic t_coincide;
    bus_write(1'b0, 8'hA9);
    idle(1);
    bus_read(1'b0);
    idle(1);
    check("R7", "pre-clear", 32'(irq_n), 32'd1);
    bus_write(1'b1, 8'h3E); exp_reg[2] = 8'h3E;
    bus_read(1'b0);
    check("R4", "mode value", 32'(rd_val), 32'hA9);
    check("R9", "set wins over clear", 32'(irq_n), 32'd0);
    check_regs("R3");
  endtask

  task automatic t_foreign;
    bus_write(1'b0, 8'h4F);
    idle(2);
    check("R5", "deselected", 32'(unit_sel_o), 32'd0);
    check("R5", "mode kept", 32'(mode_o), 32'h9);
    check("R5", "irq kept", 32'(irq_n), 32'd0);
    bus_write(1'b1, 8'h01);
    check_regs("R5");
    bus_read(1'b1);
    check("R5", "read not driven", 32'(rd_oe_n), 32'd1);
    bus_read(1'b0);
    idle(1);
    check("R5", "irq untouched by mode read when foreign", 32'(irq_n), 32'd0);
  endtask

  task automatic t_disable;
    bus_write(1'b0, 8'hA2);
    check("R2", "ctl mode", 32'(mode_o), 32'h2);
    check("R8", "irq released", 32'(irq_n), 32'd1);
    bus_write(1'b1, 8'h99); exp_reg[0] = 8'h99;
    idle(4);
    check("R8", "irq stays off", 32'(irq_n), 32'd1);
    check_regs("R3");
  endtask

  initial begin
    for (int i = 0; i < 3; i++) exp_reg[i] = '0;
    idle(4);
    t_reset();
    rst = 1'b0;
    idle(2);
    t_unselected();
    t_select_disabled();
    t_enable_and_latency();
    t_data_path();
    t_select_three();
    t_coincide();
    t_foreign();
    t_disable();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule